// File: doc/BRIEF.md
# Bandwidth-Aware Prefetch Pattern Selector

This block sits between a spatial pattern learning table and the prefetch address generator. For each page trigger it receives two anchored line bitmaps from the table. One is tuned for coverage and the other for accuracy. Each comes with a small saturating quality score, and a 2-bit level gives the current memory bandwidth utilization. From these inputs the block decides whether to prefetch, and with which bitmap.

The chosen bitmap is anchored: bit i means "i lines after the trigger, wrapping within the page". It is rotated into absolute line positions within the page, and the trigger line's own bit is dropped. If no bit survives, the result is reported as no prefetch. The result is registered and carries the trigger's page number.

Both edges of the block are valid/ready streams. A trigger is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. `lk_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `pf_valid` is high and `pf_ready` is low, the output holds all of its fields unchanged and no new trigger is taken. The upstream side must hold its inputs steady while `lk_valid` is high and `lk_ready` is low.

Top module: `pf_pattern_select`

## Requirements
- R1: After reset, `pf_valid` is 0 and `lk_ready` is 1.
- R2: When `bw_level` is 3 (at least 75% utilization) and `acc_score` is at its maximum value, the result is no prefetch. In that case `pf_issue` is 0, `pf_src` is 0 and `pf_lines` is all zeros.
- R3: When `bw_level` is 3 and `acc_score` is below its maximum value, the accuracy bitmap is selected (`pf_src` = 2).
- R4: When `bw_level` is 2 (50% up to 75%) and `cov_score` is at its maximum value, the accuracy bitmap is selected (`pf_src` = 2).
- R5: When `bw_level` is 2 and `cov_score` is below its maximum value, the coverage bitmap is selected (`pf_src` = 1).
- R6: When `bw_level` is 0 or 1 (below 50%), the coverage bitmap is selected (`pf_src` = 1), whatever the scores are.
- R7: Bit j of `pf_lines` equals bit ((j - `lk_offset`) mod LINES) of the selected bitmap, for every j other than the trigger line.
- R8: Bit `lk_offset` of `pf_lines` is always 0.
- R9: If the rotated bitmap, with the trigger bit cleared, has no set bit, the result is no prefetch. In that case `pf_issue` is 0, `pf_src` is 0 and `pf_lines` is 0. Otherwise `pf_issue` is 1.
- R10: A trigger accepted at a clock edge shows on the output, with `pf_valid` high and `pf_page` equal to its `lk_page`, right after that same edge.
- R11: While `pf_valid` is 1 and `pf_ready` is 0, `lk_ready` is 0 and all output fields stay stable. A new trigger is accepted in the same cycle that the held result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Trigger lookup present |
| lk_ready | output | 1 | Selector can take a trigger |
| lk_page | input | PAGE_W | Page number of the trigger |
| lk_offset | input | $clog2(LINES) | Trigger line within the page |
| cov_pat | input | LINES | Anchored coverage-biased bitmap |
| acc_pat | input | LINES | Anchored accuracy-biased bitmap |
| cov_score | input | SCORE_W | Quality score of the coverage bitmap |
| acc_score | input | SCORE_W | Quality score of the accuracy bitmap |
| bw_level | input | 2 | Quantized bandwidth utilization quartile |
| pf_valid | output | 1 | Result present |
| pf_ready | input | 1 | Consumer takes the result |
| pf_page | output | PAGE_W | Page number of the result |
| pf_lines | output | LINES | Absolute lines to prefetch |
| pf_src | output | 2 | 0 none, 1 coverage bitmap, 2 accuracy bitmap |
| pf_issue | output | 1 | 1 when a prefetch is to be issued |

## Verification
The bound checker watches several properties on every cycle: the trigger line is never set, and a no-prefetch result has an empty bitmap. It also checks that the coverage bitmap never leaves at the top bandwidth level and the accuracy bitmap never leaves below 50%. Held results must stay stable under back-pressure, and an accepted trigger must produce a result on the next cycle. The exact four-way selection, which depends on the saturation of each score, is shown only by the bench's sweep. So are the exact rotated bit positions, the empty-after-clearing case and the swap of a result under a stall.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_COV  = 2'd1,
    SRC_ACC  = 2'd2
  } src_e;

  localparam logic [1:0] BW_TOP = 2'd3;
  localparam logic [1:0] BW_MID = 2'd2;
endpackage

// File: rtl/pfs_policy.sv
module pfs_policy
  import pfs_pkg::*;
#(
  parameter int SCORE_W = 2
) (
  input  logic [1:0]         bw_level,
  input  logic [SCORE_W-1:0] cov_score,
  input  logic [SCORE_W-1:0] acc_score,
  output src_e               choice
);
  localparam logic [SCORE_W-1:0] SCORE_MAX = {SCORE_W{1'b1}};

  logic cov_full;
  logic acc_full;

  assign cov_full = (cov_score == SCORE_MAX);
  assign acc_full = (acc_score == SCORE_MAX);

  always_comb begin
    if (bw_level == BW_TOP)
      choice = acc_full ? SRC_NONE : SRC_ACC;
    else if (bw_level == BW_MID)
      choice = cov_full ? SRC_ACC : SRC_COV;
    else
      choice = SRC_COV;
  end
endmodule

// File: rtl/pfs_rotate.sv
module pfs_rotate #(
  parameter int LINES = 64,
  localparam int OFF_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] anchored,
  input  logic [OFF_W-1:0] offset,
  output logic [LINES-1:0] absolute
);
  logic [2*LINES-1:0] doubled;
  logic [LINES-1:0]   trig_mask;

  assign doubled   = {anchored, anchored} << offset;
  assign trig_mask = {{(LINES-1){1'b0}}, 1'b1} << offset;
  assign absolute  = doubled[2*LINES-1:LINES] & ~trig_mask;
endmodule

// File: rtl/pfs_hold_stage.sv
module pfs_hold_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pf_pattern_select.sv
module pf_pattern_select
  import pfs_pkg::*;
#(
  parameter int LINES   = 64,
  parameter int PAGE_W  = 36,
  parameter int SCORE_W = 2,
  localparam int OFF_W  = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [PAGE_W-1:0]  lk_page,
  input  logic [OFF_W-1:0]   lk_offset,
  input  logic [LINES-1:0]   cov_pat,
  input  logic [LINES-1:0]   acc_pat,
  input  logic [SCORE_W-1:0] cov_score,
  input  logic [SCORE_W-1:0] acc_score,
  input  logic [1:0]         bw_level,
  output logic               pf_valid,
  input  logic               pf_ready,
  output logic [PAGE_W-1:0]  pf_page,
  output logic [LINES-1:0]   pf_lines,
  output logic [1:0]         pf_src,
  output logic               pf_issue
);
  localparam int PAY_W = PAGE_W + LINES + 2;

  src_e             choice;
  logic [LINES-1:0] picked;
  logic [LINES-1:0] placed;
  logic             any_line;
  src_e             final_src;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  pfs_policy #(.SCORE_W(SCORE_W)) u_policy (
    .bw_level (bw_level),
    .cov_score(cov_score),
    .acc_score(acc_score),
    .choice   (choice)
  );

  always_comb begin
    case (choice)
      SRC_COV: picked = cov_pat;
      SRC_ACC: picked = acc_pat;
      default: picked = '0;
    endcase
  end

  pfs_rotate #(.LINES(LINES)) u_rotate (
    .anchored(picked),
    .offset  (lk_offset),
    .absolute(placed)
  );

  assign any_line  = |placed;
  assign final_src = any_line ? choice : SRC_NONE;
  assign pay_in    = {lk_page, placed, final_src};

  pfs_hold_stage #(.W(PAY_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (lk_valid),
    .in_ready (lk_ready),
    .in_data  (pay_in),
    .out_valid(pf_valid),
    .out_ready(pf_ready),
    .out_data (pay_out)
  );

  assign pf_page  = pay_out[PAY_W-1 -: PAGE_W];
  assign pf_lines = pay_out[LINES+1:2];
  assign pf_src   = pay_out[1:0];
  assign pf_issue = (pay_out[1:0] != 2'd0);
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int LINES   = 64,
  parameter int PAGE_W  = 36,
  parameter int SCORE_W = 2,
  localparam int OFF_W  = $clog2(LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic [OFF_W-1:0]   lk_offset,
  input logic [1:0]         bw_level,
  input logic               pf_valid,
  input logic               pf_ready,
  input logic [PAGE_W-1:0]  pf_page,
  input logic [LINES-1:0]   pf_lines,
  input logic [1:0]         pf_src,
  input logic               pf_issue
);
  logic [OFF_W-1:0] seen_off;
  logic [1:0]       seen_bw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_off <= '0;
      seen_bw  <= '0;
    end else if (lk_valid && lk_ready) begin
      seen_off <= lk_offset;
      seen_bw  <= bw_level;
    end
  end

  AST_TRIGGER_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !pf_lines[seen_off]); // R8

  AST_EMPTY_IS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_issue) |-> (pf_lines == '0 && pf_src == 2'd0)); // R9

  AST_ISSUE_HAS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_issue) |-> (pf_lines != '0)); // R9

  AST_TOP_BW_NO_COV: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && seen_bw == 2'd3) |-> (pf_src != 2'd1)); // R3

  AST_LOW_BW_COV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && seen_bw[1] == 1'b0) |-> (pf_src != 2'd2)); // R6

  AST_ACCEPT_TO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> pf_valid); // R10

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_page) && $stable(pf_lines) && $stable(pf_src))); // R11

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |-> !lk_ready); // R11
endmodule

bind pf_pattern_select pfs_checker #(
  .LINES(LINES), .PAGE_W(PAGE_W), .SCORE_W(SCORE_W)
) u_pfs_checker (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_offset(lk_offset), .bw_level(bw_level), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_page(pf_page), .pf_lines(pf_lines),
  .pf_src(pf_src), .pf_issue(pf_issue)
);

// File: tb/test_pf_pattern_select.sv
`timescale 1ns/1ps
module test_pf_pattern_select;
  localparam int LINES   = 8;
  localparam int PAGE_W  = 12;
  localparam int SCORE_W = 2;
  localparam int OFF_W   = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               lk_valid = 1'b0;
  logic               lk_ready;
  logic [PAGE_W-1:0]  lk_page = '0;
  logic [OFF_W-1:0]   lk_offset = '0;
  logic [LINES-1:0]   cov_pat = '0;
  logic [LINES-1:0]   acc_pat = '0;
  logic [SCORE_W-1:0] cov_score = '0;
  logic [SCORE_W-1:0] acc_score = '0;
  logic [1:0]         bw_level = '0;
  logic               pf_valid;
  logic               pf_ready = 1'b1;
  logic [PAGE_W-1:0]  pf_page;
  logic [LINES-1:0]   pf_lines;
  logic [1:0]         pf_src;
  logic               pf_issue;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pf_pattern_select #(.LINES(LINES), .PAGE_W(PAGE_W), .SCORE_W(SCORE_W)) i_pf_pattern_select (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_page(lk_page), .lk_offset(lk_offset), .cov_pat(cov_pat), .acc_pat(acc_pat),
    .cov_score(cov_score), .acc_score(acc_score), .bw_level(bw_level),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_page(pf_page),
    .pf_lines(pf_lines), .pf_src(pf_src), .pf_issue(pf_issue)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Selection by quartile and score saturation: 0 none, 1 coverage, 2 accuracy
  function automatic int want_choice(input int bw, input int cs, input int as);
    if (bw == 3) return (as == 3) ? 0 : 2;
    if (bw == 2) return (cs == 3) ? 2 : 1;
    return 1;
  endfunction

  function automatic string choice_tag(input int bw, input int cs, input int as);
    if (bw == 3) return (as == 3) ? "R2" : "R3";
    if (bw == 2) return (cs == 3) ? "R4" : "R5";
    return "R6";
  endfunction

  function automatic int place(input int pat, input int off);
    int r = 0;
    for (int j = 0; j < LINES; j++)
      if (j != off && ((pat >> ((j - off + LINES) % LINES)) & 1) != 0) r |= (1 << j);
    return r;
  endfunction

  task automatic drive(input int page, input int off, input int cp, input int ap,
                       input int cs, input int as, input int bw);
    lk_page   = PAGE_W'(page);
    lk_offset = OFF_W'(off);
    cov_pat   = LINES'(cp);
    acc_pat   = LINES'(ap);
    cov_score = SCORE_W'(cs);
    acc_score = SCORE_W'(as);
    bw_level  = 2'(bw);
  endtask

  task automatic one(input int page, input int off, input int cp, input int ap,
                     input int cs, input int as, input int bw);
    int ch, sel, lines, src;
    @(negedge clk);
    drive(page, off, cp, ap, cs, as, bw);
    lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    ch    = want_choice(bw, cs, as);
    sel   = (ch == 1) ? cp : (ch == 2) ? ap : 0;
    lines = place(sel, off);
    src   = (lines != 0) ? ch : 0;
    check(pf_valid && int'(pf_page) == page, "R10 page", int'(pf_page), page);
    check(int'(pf_src) == src, (lines == 0) ? "R9 src" : choice_tag(bw, cs, as), int'(pf_src), src);
    check(int'(pf_lines) == lines, "R7 lines", int'(pf_lines), lines);
    check(pf_lines[off] == 1'b0, "R8 trigger bit", int'(pf_lines), lines);
    check(pf_issue == (lines != 0), "R9 issue", int'(pf_issue), int'(lines != 0));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pc [4] = '{8'hB6, 8'hFF, 8'h00, 8'h5A};
    int pa [4] = '{8'h24, 8'h01, 8'h81, 8'hC3};
    int pg;
    repeat (3) @(negedge clk);
    check(pf_valid == 1'b0, "R1 valid", int'(pf_valid), 0);
    check(lk_ready == 1'b1, "R1 ready", int'(lk_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(pf_valid == 1'b0, "R1 idle", int'(pf_valid), 0);

    // Sweep of all quartiles, scores and offsets over four bitmap pairs
    pg = 1;
    for (int p = 0; p < 4; p++)
      for (int bw = 0; bw < 4; bw++)
        for (int cs = 0; cs < 4; cs++)
          for (int as = 0; as < 4; as++)
            for (int off = 0; off < LINES; off++) begin
              one(pg, off, pc[p], pa[p], cs, as, bw);
              pg = (pg * 5 + 3) % 4096;
            end

    // R11: stall, swap under stall, release
    @(negedge clk);
    pf_ready = 1'b0;
    drive(12'h0A1, 2, 8'h0F, 8'h30, 0, 0, 0);
    lk_valid = 1'b1;
    @(negedge clk);
    drive(12'h0B2, 5, 8'h0F, 8'h30, 0, 0, 3);
    check(lk_ready == 1'b0, "R11 ready low", int'(lk_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(pf_valid && pf_page == 12'h0A1 && int'(pf_lines) == place(8'h0F, 2),
            "R11 hold", int'(pf_page), 12'h0A1);
    end
    pf_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check(pf_valid && pf_page == 12'h0B2, "R11 swap", int'(pf_page), 12'h0B2);
    check(pf_src == 2'd2 && int'(pf_lines) == place(8'h30, 5), "R3 swap",
          int'(pf_lines), place(8'h30, 5));
    @(negedge clk);
    check(pf_valid == 1'b0, "R11 drain", int'(pf_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule